// File: doc/BRIEF.md
# Board Control and Status Register Bank

This block is a small bus slave that exposes three 32-bit words to software over a single-cycle-acknowledge, Wishbone-style handshake. Word 0 returns a board identifier taken from an input port. Word 1 is the control/status word. It carries five writable test enables that drive output pins, a read-only hardware version, the switch and detection lines, an unlock bit with a guarded reset request, and two sticky error flags. Word 2 reports the live state of the front, inverted-front and rear input lines.

The line inputs (switches, detection, front, inverted front, rear) are asynchronous and pass through two-flop synchronizers before they are read. The two error flags are set by single-cycle hardware event inputs and cleared by writing 1 to their bit positions. The reset request leaves the block as a one-cycle pulse, and only when the same write also sets the unlock bit. The logic that consumes the enables, the reset pulse and the events sits outside this block.

Top module: `brd_regbank`

## Requirements
- R1: While reset is asserted, `bus_ack`, `bus_rdat`, `ctrl_en` and `logic_rst` are all 0, and the unlock bit and both flags are cleared.
- R2: An access presented with `bus_cyc` and `bus_stb` high while `bus_ack` is low is accepted at the next rising edge. `bus_ack` is high for exactly the one cycle that follows, and `bus_rdat` is valid in that cycle.
- R3: Word address 0 reads back `board_id`, and writes to it have no effect.
- R4: Word 1 bits 4:0 are read/write and drive `ctrl_en[4:0]` (bit 0 channel LED sequencing, 1 status LED sequencing, 2 rear LED lines high, 3 TTL test pulses, 4 rear pulse generation). Bit 14 is the read/write unlock bit.
- R5: Word 1 reads `hw_version` in bits 13:8, the switches in 23:16 and the detection lines in 29:24. The line values are synchronized: a read accepted on the second edge after a line change still returns the old value, and later reads return the new one.
- R6: A write to word 1 with bits 15 and 14 both 1 raises `logic_rst` for exactly one cycle, the cycle in which `bus_ack` is high. With bit 14 at 0 in that write, no pulse occurs. Bit 15 always reads back 0.
- R7: Word 1 bit 30 is set by `evt_addr_err` and bit 31 by `evt_wdog`. Each stays set until a write to word 1 has a 1 in its bit. A 0 in that bit leaves the flag unchanged.
- R8: If a set event and a write-1 clear of the same flag occur in the same cycle, the flag ends up set.
- R9: Word 2 holds the front inputs in bits 5:0, the inverted-front inputs in bits 9:6 and the rear inputs in bits 15:10, with channel 1 at the low bit of each field. Bits 31:16 read 0, and writes to word 2 have no effect.
- R10: Word 1 bits 7:5 read 0 whatever was written. Word address 3 reads 0, and writing it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_adr | input | 2 | Word address |
| bus_wdat | input | 32 | Write data |
| bus_rdat | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| board_id | input | 32 | Board identifier value |
| hw_version | input | 6 | Hardware version (major in 5:2, revision in 1:0) |
| switch_in | input | 8 | Switch lines, asynchronous |
| detect_in | input | 6 | Detection lines, asynchronous |
| front_in | input | 6 | Front channel lines, asynchronous |
| front_inv_in | input | 4 | Inverted-front channel lines, asynchronous |
| rear_in | input | 6 | Rear channel lines, asynchronous |
| evt_addr_err | input | 1 | Set pulse for the bad-address error flag |
| evt_wdog | input | 1 | Set pulse for the watchdog timeout flag |
| ctrl_en | output | 5 | Test enable outputs |
| logic_rst | output | 1 | One-cycle reset request pulse |

## Verification
The hardest situation to reach from the ports is a hardware set event that lands in the same clock edge that accepts a write-1 clear of that flag. The bench drives the event and the strobe from the same falling edge and holds both for exactly one rising edge, then reads the word back to see that the flag survived. The synchronizer latency is pinned down in a similar way. A line change is followed at once by a read whose acceptance edge is the second after the change, so that read must still return the old value, and the next read must return the new one.

// File: rtl/brd_regs_pkg.sv
package brd_regs_pkg;
  localparam int DATA_W = 32;

  // word addresses
  localparam int WORD_ID    = 0;
  localparam int WORD_CSR   = 1;
  localparam int WORD_LINES = 2;

  // control/status word layout
  localparam int EN_LSB     = 0;
  localparam int EN_W       = 5;
  localparam int HWV_LSB    = 8;
  localparam int HWV_W      = 6;
  localparam int UNLOCK_BIT = 14;
  localparam int RSTREQ_BIT = 15;
  localparam int SW_LSB     = 16;
  localparam int SW_W       = 8;
  localparam int DET_LSB    = 24;
  localparam int DET_W      = 6;
  localparam int FLAG_LSB   = 30;
  localparam int FLAG_N     = 2;   // [0] bad address, [1] watchdog

  // line status word layout
  localparam int FR_LSB  = 0;
  localparam int FR_W    = 6;
  localparam int INV_LSB = 6;
  localparam int INV_W   = 4;
  localparam int RR_LSB  = 10;
  localparam int RR_W    = 6;

  localparam int LINES_W = SW_W + DET_W + FR_W + INV_W + RR_W;
endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/brd_sticky.sv
module brd_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_d;
    logic flag_q;

    // a set event outranks a clear in the same cycle
    always_comb begin
      flag_d = flag_q;
      if (clr_i[i]) flag_d = 1'b0;
      if (set_i[i]) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign flag_o[i] = flag_q;
  end
endmodule

// File: rtl/brd_rdmux.sv
module brd_rdmux
  import brd_regs_pkg::*;
#(
  parameter int ADR_W = 2
) (
  input  logic [ADR_W-1:0]  adr,
  input  logic [DATA_W-1:0] board_id,
  input  logic [EN_W-1:0]   en,
  input  logic              unlock,
  input  logic [HWV_W-1:0]  hwv,
  input  logic [SW_W-1:0]   sw,
  input  logic [DET_W-1:0]  det,
  input  logic [FLAG_N-1:0] flags,
  input  logic [FR_W-1:0]   front,
  input  logic [INV_W-1:0]  inv,
  input  logic [RR_W-1:0]   rear,
  output logic [DATA_W-1:0] rd
);
  always_comb begin
    rd = '0;
    if (adr == ADR_W'(WORD_ID)) begin
      rd = board_id;
    end else if (adr == ADR_W'(WORD_CSR)) begin
      rd[EN_LSB +: EN_W]     = en;
      rd[HWV_LSB +: HWV_W]   = hwv;
      rd[UNLOCK_BIT]         = unlock;
      rd[SW_LSB +: SW_W]     = sw;
      rd[DET_LSB +: DET_W]   = det;
      rd[FLAG_LSB +: FLAG_N] = flags;
    end else if (adr == ADR_W'(WORD_LINES)) begin
      rd[FR_LSB +: FR_W]     = front;
      rd[INV_LSB +: INV_W]   = inv;
      rd[RR_LSB +: RR_W]     = rear;
    end
  end
endmodule

// File: rtl/brd_regbank.sv
module brd_regbank
  import brd_regs_pkg::*;
#(
  parameter int ADR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADR_W-1:0]  bus_adr,
  input  logic [DATA_W-1:0] bus_wdat,
  output logic [DATA_W-1:0] bus_rdat,
  output logic              bus_ack,
  input  logic [DATA_W-1:0] board_id,
  input  logic [HWV_W-1:0]  hw_version,
  input  logic [SW_W-1:0]   switch_in,
  input  logic [DET_W-1:0]  detect_in,
  input  logic [FR_W-1:0]   front_in,
  input  logic [INV_W-1:0]  front_inv_in,
  input  logic [RR_W-1:0]   rear_in,
  input  logic              evt_addr_err,
  input  logic              evt_wdog,
  output logic [EN_W-1:0]   ctrl_en,
  output logic              logic_rst
);
  logic                 ack_q, ack_d;
  logic [DATA_W-1:0]    rdat_q, rdat_d;
  logic [EN_W-1:0]      en_q, en_d;
  logic                 unlock_q, unlock_d;
  logic                 rstp_q, rstp_d;
  logic                 accept, csr_wr;
  logic [FLAG_N-1:0]    flag_q, flag_set, flag_clr;
  logic [LINES_W-1:0]   lines_raw, lines_s;
  logic [DATA_W-1:0]    rd_word;

  // asynchronous line inputs, synchronized as one vector
  assign lines_raw = {rear_in, front_inv_in, front_in, detect_in, switch_in};

  brd_sync #(.W(LINES_W)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (lines_raw),
    .q (lines_s)
  );

  assign accept = bus_cyc & bus_stb & ~ack_q;
  assign csr_wr = accept & bus_we & (bus_adr == ADR_W'(WORD_CSR));

  assign flag_set = {evt_wdog, evt_addr_err};
  assign flag_clr = {FLAG_N{csr_wr}} & bus_wdat[FLAG_LSB +: FLAG_N];

  brd_sticky #(.N(FLAG_N)) u_flags (
    .clk (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .flag_o (flag_q)
  );

  brd_rdmux #(.ADR_W(ADR_W)) u_rdmux (
    .adr (bus_adr),
    .board_id (board_id),
    .en (en_q),
    .unlock (unlock_q),
    .hwv (hw_version),
    .sw (lines_s[0 +: SW_W]),
    .det (lines_s[SW_W +: DET_W]),
    .flags (flag_q),
    .front (lines_s[SW_W+DET_W +: FR_W]),
    .inv (lines_s[SW_W+DET_W+FR_W +: INV_W]),
    .rear (lines_s[SW_W+DET_W+FR_W+INV_W +: RR_W]),
    .rd (rd_word)
  );

  // next state
  always_comb begin
    ack_d    = accept;
    rdat_d   = rdat_q;
    en_d     = en_q;
    unlock_d = unlock_q;
    rstp_d   = 1'b0;
    if (accept) rdat_d = rd_word;
    if (csr_wr) begin
      en_d     = bus_wdat[EN_LSB +: EN_W];
      unlock_d = bus_wdat[UNLOCK_BIT];
      rstp_d   = bus_wdat[RSTREQ_BIT] & bus_wdat[UNLOCK_BIT];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      rdat_q   <= '0;
      en_q     <= '0;
      unlock_q <= 1'b0;
      rstp_q   <= 1'b0;
    end else begin
      ack_q    <= ack_d;
      rstp_q   <= rstp_d;
      if (accept) rdat_q   <= rdat_d;
      if (csr_wr) begin
        en_q     <= en_d;
        unlock_q <= unlock_d;
      end
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdat  = rdat_q;
  assign ctrl_en   = en_q;
  assign logic_rst = rstp_q;
endmodule

// File: rtl/brd_regbank_chk.sv
module brd_regbank_chk #(
  parameter int ADR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_cyc,
  input logic             bus_stb,
  input logic             bus_we,
  input logic [ADR_W-1:0] bus_adr,
  input logic [31:0]      bus_wdat,
  input logic [31:0]      bus_rdat,
  input logic             bus_ack,
  input logic             evt_addr_err,
  input logic             evt_wdog,
  input logic             logic_rst,
  input logic [1:0]       flags
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack); // R2
  AST_ACK_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_cyc && bus_stb)); // R2
  AST_RST_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |-> (bus_ack && $past(bus_we && bus_wdat[15] && bus_wdat[14] && bus_adr == ADR_W'(1)))); // R6
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst |=> !logic_rst); // R6
  AST_ADDR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_addr_err |=> flags[0]); // R8
  AST_WDOG_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wdog |=> flags[1]); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(bus_cyc && bus_stb && !bus_ack && bus_we && bus_adr == ADR_W'(1) && bus_wdat[30])) |=> flags[0]); // R7
  AST_LINES_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && $past(bus_adr == ADR_W'(2))) |-> (bus_rdat[31:16] == 16'h0)); // R9
endmodule

bind brd_regbank brd_regbank_chk #(.ADR_W(ADR_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .bus_cyc (bus_cyc),
  .bus_stb (bus_stb),
  .bus_we (bus_we),
  .bus_adr (bus_adr),
  .bus_wdat (bus_wdat),
  .bus_rdat (bus_rdat),
  .bus_ack (bus_ack),
  .evt_addr_err (evt_addr_err),
  .evt_wdog (evt_wdog),
  .logic_rst (logic_rst),
  .flags (flag_q)
);

// File: tb/brd_regbank_bench.sv
module brd_regbank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_cyc, bus_stb, bus_we;
  logic [1:0]  bus_adr;
  logic [31:0] bus_wdat, bus_rdat;
  logic        bus_ack;
  logic [31:0] board_id;
  logic [5:0]  hw_version;
  logic [7:0]  switch_in;
  logic [5:0]  detect_in;
  logic [5:0]  front_in;
  logic [3:0]  front_inv_in;
  logic [5:0]  rear_in;
  logic        evt_addr_err, evt_wdog;
  logic [4:0]  ctrl_en;
  logic        logic_rst;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brd_regbank u_brd_regbank (
    .clk (clk), .rst_n (rst_n),
    .bus_cyc (bus_cyc), .bus_stb (bus_stb), .bus_we (bus_we),
    .bus_adr (bus_adr), .bus_wdat (bus_wdat), .bus_rdat (bus_rdat),
    .bus_ack (bus_ack), .board_id (board_id), .hw_version (hw_version),
    .switch_in (switch_in), .detect_in (detect_in), .front_in (front_in),
    .front_inv_in (front_inv_in), .rear_in (rear_in),
    .evt_addr_err (evt_addr_err), .evt_wdog (evt_wdog),
    .ctrl_en (ctrl_en), .logic_rst (logic_rst)
  );

  // vector: {we, adr[1:0], wdata[31:0], expected read data[31:0]}
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 32'h0,          32'hA5C3_0F12}, // R3 id
    {1'b1, 2'd0, 32'hFFFF_FFFF,  32'h0},         // R3 write ignored
    {1'b0, 2'd0, 32'h0,          32'hA5C3_0F12}, // R3
    {1'b0, 2'd2, 32'h0,          32'h0000_CE95}, // R9 lines
    {1'b1, 2'd2, 32'hFFFF_FFFF,  32'h0},         // R9 write ignored
    {1'b0, 2'd2, 32'h0,          32'h0000_CE95}, // R9
    {1'b0, 2'd1, 32'h0,          32'h2A3C_1200}, // R5 fields
    {1'b1, 2'd1, 32'h0000_00FF,  32'h0},         // R4 / R10 reserved
    {1'b0, 2'd1, 32'h0,          32'h2A3C_121F}, // R4 R10
    {1'b1, 2'd1, 32'h0000_4015,  32'h0},         // R4 unlock
    {1'b0, 2'd1, 32'h0,          32'h2A3C_5215}, // R4
    {1'b1, 2'd3, 32'hFFFF_FFFF,  32'h0},         // R10 unmapped write
    {1'b0, 2'd3, 32'h0,          32'h0},         // R10 unmapped read
    {1'b0, 2'd1, 32'h0,          32'h2A3C_5215}  // R10 no state change
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; returns read data and logic_rst sampled with ack and one cycle later
  task automatic xfer(input logic we, input logic [1:0] adr, input logic [31:0] wd,
                      output logic [31:0] rd, output logic rst_at_ack, output logic rst_after);
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = we; bus_adr = adr; bus_wdat = wd;
    @(negedge clk);
    check("R2 ack after accept", {31'b0, bus_ack}, 32'd1);
    rd = bus_rdat;
    rst_at_ack = logic_rst;
    bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    check("R2 ack single cycle", {31'b0, bus_ack}, 32'd0);
    rst_after = logic_rst;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] adr, input logic [31:0] exp);
    logic [31:0] r;
    logic a, b;
    xfer(1'b0, adr, 32'h0, r, a, b);
    check(req, r, exp);
  endtask

  task automatic wr(input logic [1:0] adr, input logic [31:0] wd);
    logic [31:0] r;
    logic a, b;
    xfer(1'b1, adr, wd, r, a, b);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic pa, pb;
    rst_n = 1'b0;
    bus_cyc = 0; bus_stb = 0; bus_we = 0; bus_adr = 0; bus_wdat = 0;
    board_id = 32'hA5C3_0F12; hw_version = 6'b010010;
    switch_in = 8'h3C; detect_in = 6'h2A;
    front_in = 6'h15; front_inv_in = 4'hA; rear_in = 6'h33;
    evt_addr_err = 0; evt_wdog = 0;
    repeat (3) @(negedge clk);
    check("R1 ack in reset", {31'b0, bus_ack}, 32'd0);
    check("R1 rdat in reset", bus_rdat, 32'd0);
    check("R1 ctrl_en in reset", {27'b0, ctrl_en}, 32'd0);
    check("R1 logic_rst in reset", {31'b0, logic_rst}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [66:0] v;
      v = VEC[i];
      if (v[66]) wr(v[65:64], v[63:32]);
      else rd_chk("R3/R4/R5/R9/R10 table", v[65:64], v[31:0]);
    end
    check("R4 ctrl_en drives outputs", {27'b0, ctrl_en}, 32'h15);

    // R6: request without unlock gives no pulse
    xfer(1'b1, 2'd1, 32'h0000_8000, r, pa, pb);
    check("R6 no pulse when locked", {30'b0, pa, pb}, 32'd0);
    rd_chk("R6 bit15 reads 0, unlock cleared", 2'd1, 32'h2A3C_1200);
    xfer(1'b1, 2'd1, 32'h0000_C015, r, pa, pb);
    check("R6 one-cycle pulse with ack", {30'b0, pa, pb}, 32'd2);
    rd_chk("R6 bit15 reads 0", 2'd1, 32'h2A3C_5215);

    // R7: sticky flags
    @(negedge clk); evt_addr_err = 1'b1;
    @(negedge clk); evt_addr_err = 1'b0;
    rd_chk("R7 addr flag set", 2'd1, 32'h6A3C_5215);
    @(negedge clk); evt_wdog = 1'b1;
    @(negedge clk); evt_wdog = 1'b0;
    rd_chk("R7 wdog flag set", 2'd1, 32'hEA3C_5215);
    wr(2'd1, 32'h0000_4015);
    rd_chk("R7 write 0 keeps flags", 2'd1, 32'hEA3C_5215);
    wr(2'd1, 32'h4000_4015);
    rd_chk("R7 write 1 clears addr flag", 2'd1, 32'hAA3C_5215);
    wr(2'd1, 32'h8000_4015);
    rd_chk("R7 write 1 clears wdog flag", 2'd1, 32'h2A3C_5215);

    // R8: set and clear on the same edge
    @(negedge clk);
    bus_cyc = 1'b1; bus_stb = 1'b1; bus_we = 1'b1; bus_adr = 2'd1;
    bus_wdat = 32'h4000_4015; evt_addr_err = 1'b1;
    @(negedge clk);
    evt_addr_err = 1'b0; bus_cyc = 1'b0; bus_stb = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    rd_chk("R8 set wins over clear", 2'd1, 32'h6A3C_5215);
    wr(2'd1, 32'h4000_4015);
    rd_chk("R8 later clear works", 2'd1, 32'h2A3C_5215);

    // R5: synchronizer latency
    switch_in = 8'hC3; detect_in = 6'h15;
    rd_chk("R5 old value inside sync window", 2'd1, 32'h2A3C_5215);
    rd_chk("R5 new value after sync", 2'd1, 32'h15C3_5215);
    front_in = 6'h2A; front_inv_in = 4'h5; rear_in = 6'h0C;
    repeat (3) @(negedge clk);
    rd_chk("R9 new line pattern", 2'd2, 32'h0000_316A);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule